// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised number of 32-bit words of level-sensitive interrupt sources (one to sixteen words, so up to 512 lines) and folds them into one output interrupt line. Software reaches it through a small synchronous register bus with byte addresses. For every word it has an enable mask, a force register that can drive any source active from software, and a read-only pending view. A summary register shows which words hold pending bits. A channel enable and a master disable decide whether the pending state reaches the output.

The register layout grows with the word count. The per-word banks sit back to back after the control word, and the two summary registers follow them. A build-time switch reverses the order in which logical source words occupy the physical register slots. Sources pass through a two-flop synchronizer. Nothing is acknowledged: a bit stays pending exactly as long as its cause lasts.

Top module: `irq_steer_agg`

## Requirements
- R1: After the synchronous active-high reset, every readable register reads 0, `rdata` is 0 and `irq_out` is 0.
- R2: The control register at byte offset 0x0 holds one writable bit (bit 0) that enables the output. While it is 0, `irq_out` stays 0 whatever is pending.
- R3: With W words, the mask word for physical index k is read/write at offset 0x4 + 4k. Its value changes only through a write to that offset.
- R4: The force word for physical index k is read/write at offset 0x4 + 4k + 4W. A 1 in it makes the matching source pending as if its input were high.
- R5: The pending word for physical index k at offset 0x4 + 4k + 8W reads (synchronized input | force) & mask. It is read-only, and writes to it have no effect.
- R6: The master disable register at 0x4 + 12W holds a read/write bit 0. While that bit is 1, `irq_out` stays 0.
- R7: The summary register at 0x8 + 12W is read-only. Its bit k is 1 exactly when pending word k is nonzero, so it reads nonzero whenever anything is pending.
- R8: `irq_out` is a register loaded with enable & !disable & (any pending). A change on an input bit shows at `irq_out` after the third rising clock edge: two synchronizer stages, then the output flop.
- R9: Input bit j of logical word i is interrupt 32*i + j and arrives on `src_in[32*i + j]`. With the reverse switch clear, logical word i uses physical index i. With it set, logical word i uses physical index W-1-i in the mask, force and pending banks.
- R10: A read of an unmapped or unaligned offset (addr[1:0] nonzero) returns 0. A write there changes no register.
- R11: Pending bits are level-sensitive. When the source and its force bit both drop, the pending bit and `irq_out` clear without any acknowledge.
- R12: `rdata` is loaded at the clock edge where `rd_en` is high, with the value at `addr`. It holds that value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32*NUM_WORDS | Level-sensitive interrupt sources, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined output interrupt |

## Verification
The embedded assertions check on every cycle that a high `irq_out` always follows a cycle in which the channel was enabled, the master disable was clear and something was pending. They also check that an unmapped read returns zero and that the mask bank holds still when no write occurs. The pending formula, the physical placement of words under each reverse setting, the three-edge input latency and the read-only behaviour of the status registers only show up in the bench. It runs two instances, one with each word order, and compares them with its own register model over random and directed traffic.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_CTRL, K_MASK, K_FORCE, K_PEND, K_MDIS, K_SUMM
  } reg_kind_e;

  // first 32-bit slot (address >> 2) of each register group
  function automatic int slot_base(reg_kind_e kind, int words);
    case (kind)
      K_CTRL:  return 0;
      K_MASK:  return 1;
      K_FORCE: return 1 + words;
      K_PEND:  return 1 + 2 * words;
      K_MDIS:  return 1 + 3 * words;
      K_SUMM:  return 2 + 3 * words;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/irq_steer_sync.sv
module irq_steer_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_out  <= '0;
    end else begin
      stage1 <= d_in;
      d_out  <= stage1;
    end
  end
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_WORDS = 1,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  input  logic [NUM_WORDS-1:0][31:0] pend,
  input  logic [NUM_WORDS-1:0]      summ,
  output logic [NUM_WORDS-1:0][31:0] mask_q,
  output logic [NUM_WORDS-1:0][31:0] force_q,
  output logic                      chan_en,
  output logic                      mdis,
  output logic [31:0]               rdata
);
  localparam int IW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  reg_kind_e     kind;
  logic [IW-1:0] idx;

  always_comb begin
    int slot;
    int rel;
    slot = int'(addr[ADDR_W-1:2]);
    rel  = 0;
    kind = K_NONE;
    if (addr[1:0] == 2'b00) begin
      if (slot == slot_base(K_CTRL, NUM_WORDS)) kind = K_CTRL;
      else if (slot < slot_base(K_FORCE, NUM_WORDS)) begin
        kind = K_MASK;  rel = slot - slot_base(K_MASK, NUM_WORDS);
      end else if (slot < slot_base(K_PEND, NUM_WORDS)) begin
        kind = K_FORCE; rel = slot - slot_base(K_FORCE, NUM_WORDS);
      end else if (slot < slot_base(K_MDIS, NUM_WORDS)) begin
        kind = K_PEND;  rel = slot - slot_base(K_PEND, NUM_WORDS);
      end else if (slot == slot_base(K_MDIS, NUM_WORDS)) kind = K_MDIS;
      else if (slot == slot_base(K_SUMM, NUM_WORDS)) kind = K_SUMM;
    end
    idx = rel[IW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en <= 1'b0;
      mdis    <= 1'b0;
    end else if (wr_en) begin
      if (kind == K_CTRL) chan_en <= wdata[0];
      if (kind == K_MDIS) mdis    <= wdata[0];
    end
  end

  for (genvar p = 0; p < NUM_WORDS; p++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[p]  <= '0;
        force_q[p] <= '0;
      end else if (wr_en && (int'(idx) == p)) begin
        if (kind == K_MASK)  mask_q[p]  <= wdata;
        if (kind == K_FORCE) force_q[p] <= wdata;
      end
    end
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (kind)
      K_CTRL: rd_val = {31'b0, chan_en};
      K_MDIS: rd_val = {31'b0, mdis};
      K_SUMM: rd_val = 32'(summ);
      K_MASK, K_FORCE, K_PEND:
        for (int p = 0; p < NUM_WORDS; p++)
          if (int'(idx) == p)
            rd_val = (kind == K_MASK) ? mask_q[p] :
                     (kind == K_FORCE) ? force_q[p] : pend[p];
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == K_NONE) |=> (rdata == 32'd0));

  assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_steer_core.sv
module irq_steer_core #(
  parameter int NUM_WORDS = 1,
  parameter bit WORD_REV  = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WORDS-1:0][31:0] src_sync,
  input  logic [NUM_WORDS-1:0][31:0] mask_q,
  input  logic [NUM_WORDS-1:0][31:0] force_q,
  input  logic                       chan_en,
  input  logic                       mdis,
  output logic [NUM_WORDS-1:0][31:0] pend,
  output logic [NUM_WORDS-1:0]       summ,
  output logic                       irq_out
);
  for (genvar p = 0; p < NUM_WORDS; p++) begin : g_phys
    localparam int LW = WORD_REV ? (NUM_WORDS - 1 - p) : p;
    assign pend[p] = (src_sync[LW] | force_q[p]) & mask_q[p];
    assign summ[p] = |pend[p];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= chan_en & ~mdis & (|summ);
  end

  assert_out_chan_R2: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(chan_en));

  assert_out_mdis_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> !$past(mdis));

  assert_out_pend_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(summ) != '0));
endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg #(
  parameter int NUM_WORDS = 1,
  parameter bit WORD_REV  = 1'b0,
  parameter int ADDR_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [32*NUM_WORDS-1:0]  src_in,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic                     irq_out
);
  localparam int NSRC = 32 * NUM_WORDS;

  logic [NSRC-1:0]                sync_flat;
  logic [NUM_WORDS-1:0][31:0]     src_sync;
  logic [NUM_WORDS-1:0][31:0]     mask_q;
  logic [NUM_WORDS-1:0][31:0]     force_q;
  logic [NUM_WORDS-1:0][31:0]     pend;
  logic [NUM_WORDS-1:0]           summ;
  logic                           chan_en;
  logic                           mdis;

  irq_steer_sync #(.WIDTH(NSRC)) u_sync (
    .clk(clk), .rst(rst), .d_in(src_in), .d_out(sync_flat)
  );

  assign src_sync = sync_flat;

  irq_steer_regs #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .pend(pend), .summ(summ), .mask_q(mask_q),
    .force_q(force_q), .chan_en(chan_en), .mdis(mdis), .rdata(rdata)
  );

  irq_steer_core #(.NUM_WORDS(NUM_WORDS), .WORD_REV(WORD_REV)) u_core (
    .clk(clk), .rst(rst), .src_sync(src_sync), .mask_q(mask_q),
    .force_q(force_q), .chan_en(chan_en), .mdis(mdis), .pend(pend),
    .summ(summ), .irq_out(irq_out)
  );
endmodule

// File: tb/irq_steer_agg_test.sv
module irq_steer_agg_test;
  localparam int W  = 2;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [32*W-1:0] src = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata0, rdata1;
  logic          irq0, irq1;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // model state, by physical index
  logic [31:0] m_mask [W];
  logic [31:0] m_force[W];
  logic        m_ctrl, m_mdis;

  always #5 clk = ~clk;

  irq_steer_agg #(.NUM_WORDS(W), .WORD_REV(1'b0), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .src_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata0), .irq_out(irq0));

  irq_steer_agg #(.NUM_WORDS(W), .WORD_REV(1'b1), .ADDR_W(AW)) uut_rev (
    .clk(clk), .rst(rst), .src_in(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata1), .irq_out(irq1));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] exp_pend(bit rev, int p);
    int lw;
    lw = rev ? (W - 1 - p) : p;
    return (src[32*lw +: 32] | m_force[p]) & m_mask[p];
  endfunction

  function automatic logic [31:0] exp_summ(bit rev);
    logic [31:0] s;
    s = '0;
    for (int p = 0; p < W; p++) s[p] = |exp_pend(rev, p);
    return s;
  endfunction

  function automatic logic exp_irq(bit rev);
    return m_ctrl & ~m_mdis & (exp_summ(rev) != 0);
  endfunction

  function automatic logic [31:0] exp_read(bit rev, int a);
    int s;
    s = a >> 2;
    if ((a & 3) != 0) return '0;
    if (s == 0) return {31'b0, m_ctrl};
    if (s >= 1 && s <= W) return m_mask[s-1];
    if (s >= W+1 && s <= 2*W) return m_force[s-1-W];
    if (s >= 2*W+1 && s <= 3*W) return exp_pend(rev, s-1-2*W);
    if (s == 3*W+1) return {31'b0, m_mdis};
    if (s == 3*W+2) return exp_summ(rev);
    return '0;
  endfunction

  task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
    total = total + 1;
    if (got !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    int s;
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    s = a >> 2;
    if ((a & 3) == 0) begin
      if (s == 0) m_ctrl = d[0];
      else if (s >= 1 && s <= W) m_mask[s-1] = d;
      else if (s >= W+1 && s <= 2*W) m_force[s-1-W] = d;
      else if (s == 3*W+1) m_mdis = d[0];
    end
  endtask

  task automatic rdc(int a, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(rdata0, exp_read(1'b0, a), tag);
    check(rdata1, exp_read(1'b1, a), {tag, " rev"});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a <= 4*(3*W+4); a += 4) rdc(a, tag);
  endtask

  task automatic chk_irq(string tag);
    check({31'b0, irq0}, {31'b0, exp_irq(1'b0)}, tag);
    check({31'b0, irq1}, {31'b0, exp_irq(1'b1)}, {tag, " rev"});
  endtask

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    for (int p = 0; p < W; p++) begin m_mask[p] = '0; m_force[p] = '0; end
    m_ctrl = 1'b0; m_mdis = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    check(rdata0, 32'd0, "R1 rdata");
    chk_irq("R1 irq_out");
    sweep("R1 reset regs");

    // R3, R4: mask and force read back
    wr(4, 32'hA5A5_0F0F); wr(8, 32'h1234_5678);
    wr(4 + 4*W, 32'h0000_0100); wr(8 + 4*W, 32'h8000_0000);
    sweep("R3 R4 readback");

    // R4, R2: force drives output once enabled
    wr(0, 32'hFFFF_FFFE);
    settle(); chk_irq("R2 ctrl clear blocks");
    wr(0, 32'h1);
    settle(); chk_irq("R4 force raises irq");

    // R6: master disable
    wr(4 + 12*W, 32'h1);
    settle(); chk_irq("R6 disable blocks");
    rdc(4 + 12*W, "R6 readback");
    wr(4 + 12*W, 32'h0);
    settle(); chk_irq("R6 re-enabled");

    // R5, R7: read-only pending and summary
    wr(4 + 8*W, 32'hFFFF_FFFF); wr(8 + 12*W, 32'hFFFF_FFFF);
    sweep("R5 R7 read-only");

    // R10: unmapped/unaligned
    wr(4*(3*W+3), 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); wr(8'hFC, 32'h1);
    rdc(4*(3*W+3), "R10 unmapped read");
    rdc(6, "R10 unaligned read");
    rdc(8'hF0, "R10 high read");
    sweep("R10 no side effect");

    // R9: word order
    for (int p = 0; p < W; p++) begin
      wr(4 + 4*p, 32'hFFFF_FFFF); wr(4 + 4*W + 4*p, 32'h0);
    end
    src = {32'hBEEF_0002, 32'h0000_C001};
    settle();
    rdc(4 + 8*W, "R9 pend word0");
    rdc(8 + 8*W, "R9 pend word1");
    rdc(8 + 12*W, "R9 summary");

    // R8, R11: latency and level behaviour
    src = '0;
    wr(4, 32'h1); wr(8, 32'h0);
    settle(); chk_irq("R11 idle");
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk); check({31'b0, irq0}, 32'd0, "R8 edge1");
    @(negedge clk); check({31'b0, irq0}, 32'd0, "R8 edge2");
    @(negedge clk); check({31'b0, irq0}, 32'd1, "R8 edge3");
    src[0] = 1'b0;
    @(negedge clk); check({31'b0, irq0}, 32'd1, "R11 edge1");
    @(negedge clk); check({31'b0, irq0}, 32'd1, "R11 edge2");
    @(negedge clk); check({31'b0, irq0}, 32'd0, "R11 cleared");
    rdc(4 + 8*W, "R11 pend cleared");

    // R12: rdata holds
    wr(4, 32'h5A5A_1234);
    rdc(4, "R12 read");
    held = rdata0;
    repeat (3) @(negedge clk);
    check(rdata0, held, "R12 hold");

    // random traffic: R5 R7 R8 R9
    for (int it = 0; it < 150; it++) begin
      int sel;
      sel = int'($urandom % 6);
      if ($urandom % 2 == 0) src = {$urandom & $urandom, $urandom & $urandom};
      case (sel)
        0: wr(0, ($urandom % 4 != 0) ? 32'h1 : 32'h0);
        1: wr(4 + 12*W, ($urandom % 5 == 0) ? 32'h1 : 32'h0);
        2, 3: wr(4 + 4*int'($urandom % W), $urandom & $urandom);
        default: wr(4 + 4*W + 4*int'($urandom % W), $urandom & $urandom & $urandom);
      endcase
      settle();
      chk_irq("R8 random irq");
      for (int p = 0; p < W; p++) rdc(4 + 8*W + 4*p, "R5 R9 random pend");
      rdc(8 + 12*W, "R7 random summary");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule